// File: doc/BRIEF.md
# Timed Job Ring Dispatcher

This block queues transfer jobs for a single DMA channel. Each job is just the head address of a descriptor chain, and the block stores jobs in a small ring of slots. It hands jobs to the channel one at a time, in the order they were submitted. Every accepted job gets a 32-bit handle, and the handles count up by one from 1 after reset. A query port takes any handle and reports whether that job is still pending. The check uses wrapping arithmetic inside a 2^23 window, so the answer stays correct when the counters wrap.

The channel itself is outside the block. It is modelled by two status inputs, a done flag and an enable flag. The block drives a start pulse that carries the chain address, an abort pulse and a pulse that clears the done flag. It also holds a level that asks for the channel to be switched off. A job that runs too long without finishing is aborted. The abort is repeated every timeout period until the channel drops its enable, and that drop counts as the end of the job. Finished slots are retired in ring order, which returns them for reuse, and each retirement reports whether that job was aborted.

Top module: `blit_ring_ctrl`

## Requirements
- R1: A submission is accepted in any cycle where `sub_valid` and `sub_ready` are both high. `sub_handle` in that cycle equals the previous handle plus one, and the first handle after reset is 1.
- R2: Jobs are started in submission order. When the channel is idle and a job is waiting, `start` pulses for one cycle and `start_addr` carries that job's chain address.
- R3: While a job is active, a high `chan_done` finishes it. `clear_done` pulses in the cycle after `chan_done` was sampled high.
- R4: If a job stays active for TIMEOUT cycles, `abort` pulses exactly TIMEOUT cycles after its `start` pulse. While the job remains unfinished, `abort` pulses again every TIMEOUT cycles. `abort` never pulses for a job that finishes earlier.
- R5: After an abort, a low `chan_en` finishes the job even though `chan_done` never rose. `clear_done` pulses in the next cycle and the slot is marked aborted.
- R6: Finished slots are retired in ring order 0,1,..,SLOTS-1,0,... Each retirement shows `ret_valid` high for one cycle with the slot index on `ret_slot`, and `ret_aborted` is 1 exactly when that job was aborted.
- R7: `q_pending` is high exactly when (done count − `q_handle`) > 2^23 and (issued count − `q_handle`) ≤ 2^23, both taken modulo 2^32. A handle is therefore pending from its acceptance until its job finishes, and never before it is issued.
- R8: `chan_off` is high exactly when no job is active and none is waiting. It is high after reset.
- R9: `sub_ready` is low while all SLOTS slots are occupied by jobs that have not been retired. A `sub_valid` pulse while `sub_ready` is low is ignored, so the next accepted job gets the next unused handle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submit a job |
| sub_addr | input | AW | Chain head address of the submitted job |
| sub_ready | output | 1 | A free slot exists |
| sub_handle | output | 32 | Handle given to a job accepted this cycle |
| chan_done | input | 1 | Channel transfer-done status |
| chan_en | input | 1 | Channel enable status |
| start | output | 1 | One-cycle start pulse |
| start_addr | output | AW | Chain address for the started job |
| abort | output | 1 | One-cycle abort pulse |
| clear_done | output | 1 | One-cycle pulse clearing the channel's done flag |
| chan_off | output | 1 | Channel may be switched off |
| ret_valid | output | 1 | A finished slot is retired this cycle |
| ret_slot | output | $clog2(SLOTS) | Index of the retired slot |
| ret_aborted | output | 1 | The retired job was aborted |
| q_handle | input | 32 | Handle to query |
| q_pending | output | 1 | Queried handle is still pending |

## Verification
Some properties are checked by the assertions on every cycle:
- the free-slot count stays within its bounds;
- the handle advances only on accepted submissions, and a refused submission leaves it unchanged;
- the done count moves with each `clear_done`;
- an abort is only issued for an active job that is marked as aborting;
- a handle that has not yet been issued never reads as pending.

Other properties need the bench's scenarios, which run a channel model against the block:
- the exact timeout spacing between start and abort pulses;
- jobs dispatched in submission order with the right addresses;
- the retirement order and the aborted flag it reports;
- a full ring refusing a job and the handle sequence carrying on correctly afterwards.

// File: rtl/blit_ring_ctrl.sv
module blit_ring_ctrl #(
  parameter int SLOTS   = 4,
  parameter int TIMEOUT = 100_000_000,
  parameter int AW      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sub_valid,
  input  logic [AW-1:0]            sub_addr,
  output logic                     sub_ready,
  output logic [31:0]              sub_handle,
  input  logic                     chan_done,
  input  logic                     chan_en,
  output logic                     start,
  output logic [AW-1:0]            start_addr,
  output logic                     abort,
  output logic                     clear_done,
  output logic                     chan_off,
  output logic                     ret_valid,
  output logic [$clog2(SLOTS)-1:0] ret_slot,
  output logic                     ret_aborted,
  input  logic [31:0]              q_handle,
  output logic                     q_pending
);
  localparam int IW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [31:0] WINDOW = 32'h0080_0000;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(SLOTS - 1)) ? '0 : i + 1'b1;
  endfunction

  logic [AW-1:0] chain [SLOTS];
  logic [SLOTS-1:0] abt;
  logic [IW-1:0] head, cur, svc;
  logic [CW-1:0] free, outc;
  logic act, abing;
  logic [TW-1:0] timer;
  logic [31:0] cur_h, done_h;

  logic accept, fin, expire, act_after, launch, retire;
  logic [IW-1:0] cur_after;
  logic [31:0] d_gap, c_gap;

  assign sub_ready  = free != '0;
  assign sub_handle = cur_h + 32'd1;
  assign accept     = sub_valid && sub_ready;
  assign fin        = (act && chan_done) || (abing && !chan_en);
  assign expire     = act && !fin && timer == '0;
  assign act_after  = act && !fin;
  assign cur_after  = fin ? nxt(cur) : cur;
  assign launch     = !act_after && outc != '0;
  assign retire     = svc != cur;

  assign chan_off    = !act && outc == '0;
  assign ret_valid   = retire;
  assign ret_slot    = svc;
  assign ret_aborted = abt[svc];

  assign d_gap     = done_h - q_handle;
  assign c_gap     = cur_h - q_handle;
  assign q_pending = (d_gap > WINDOW) && (c_gap <= WINDOW);

  always_ff @(posedge clk)
    if (accept) chain[head] <= sub_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abt        <= '0;
      head       <= '0;
      cur        <= '0;
      svc        <= '0;
      free       <= CW'(SLOTS);
      outc       <= '0;
      act        <= 1'b0;
      abing      <= 1'b0;
      timer      <= '0;
      cur_h      <= '0;
      done_h     <= '0;
      start      <= 1'b0;
      start_addr <= '0;
      abort      <= 1'b0;
      clear_done <= 1'b0;
    end else begin
      if (accept) begin
        head  <= nxt(head);
        cur_h <= cur_h + 32'd1;
      end
      outc <= outc + CW'(accept) - CW'(launch);
      free <= free - CW'(accept) + CW'(retire);
      if (fin) begin
        abt[cur] <= abing;
        done_h   <= done_h + 32'd1;
      end
      cur   <= cur_after;
      act   <= launch || act_after;
      abing <= !fin && (expire || abing);
      if (launch || expire) timer <= TW'(TIMEOUT - 1);
      else if (act && timer != '0) timer <= timer - 1'b1;
      if (retire) svc <= nxt(svc);
      start      <= launch;
      start_addr <= chain[cur_after];
      abort      <= expire;
      clear_done <= fin;
    end
  end
endmodule

// File: rtl/blit_ring_ctrl_chk.sv
module blit_ring_ctrl_chk #(
  parameter int SLOTS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sub_valid,
  input logic                       sub_ready,
  input logic                       start,
  input logic                       abort,
  input logic                       clear_done,
  input logic                       chan_off,
  input logic [$clog2(SLOTS+1)-1:0] free,
  input logic                       act,
  input logic                       abing,
  input logic [31:0]                cur_h,
  input logic [31:0]                done_h,
  input logic [31:0]                q_handle,
  input logic                       q_pending
);
  localparam int CW = $clog2(SLOTS + 1);

  assert_free_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free <= CW'(SLOTS));

  assert_refused_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_ready |=> cur_h == $past(cur_h));

  assert_handle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ready |=> cur_h == $past(cur_h) + 32'd1);

  assert_start_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> act && !abing);

  assert_finish_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_done |-> done_h == $past(done_h) + 32'd1);

  assert_abort_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> act && abing);

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_off |-> !start && !abort);

  assert_inflight_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_h - done_h) <= 32'(SLOTS));

  assert_future_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_handle == cur_h + 32'd1 |-> !q_pending);
endmodule

bind blit_ring_ctrl blit_ring_ctrl_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
  .start(start), .abort(abort), .clear_done(clear_done), .chan_off(chan_off),
  .free(free), .act(act), .abing(abing), .cur_h(cur_h), .done_h(done_h),
  .q_handle(q_handle), .q_pending(q_pending)
);

// File: tb/test_blit_ring_ctrl.sv
`timescale 1ns/1ps
module test_blit_ring_ctrl;
  localparam int SLOTS = 4;
  localparam int TO    = 40;
  localparam int AW    = 32;

  logic clk = 0, rst_n = 0;
  logic sub_valid = 0;
  logic [AW-1:0] sub_addr = '0;
  logic sub_ready;
  logic [31:0] sub_handle;
  logic chan_done = 0, chan_en = 1;
  logic start, abort, clear_done, chan_off, ret_valid, ret_aborted, q_pending;
  logic [AW-1:0] start_addr;
  logic [$clog2(SLOTS)-1:0] ret_slot;
  logic [31:0] q_handle = '0;

  blit_ring_ctrl #(.SLOTS(SLOTS), .TIMEOUT(TO), .AW(AW)) i_blit_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_addr(sub_addr),
    .sub_ready(sub_ready), .sub_handle(sub_handle), .chan_done(chan_done),
    .chan_en(chan_en), .start(start), .start_addr(start_addr), .abort(abort),
    .clear_done(clear_done), .chan_off(chan_off), .ret_valid(ret_valid),
    .ret_slot(ret_slot), .ret_aborted(ret_aborted), .q_handle(q_handle),
    .q_pending(q_pending)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [31:0] exp_h = 0;
  logic [AW-1:0] addr_q[$];
  bit ret_q[$];
  bit hang = 0, busy = 0, exp_clr = 0, cur_abt = 0, en_low = 0;
  int left = 0, max_dly = 6, start_cyc = 0, last_abort = 0, abort_cnt = 0, en_cnt = -1;
  int exp_slot = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic bit pend_model(input logic [31:0] done_c, input logic [31:0] cur_c,
                                    input logic [31:0] h);
    return ((done_c - h) > 32'h0080_0000) && ((cur_c - h) <= 32'h0080_0000);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chan_done = 0;
      if (en_low) begin chan_en = 1; en_low = 0; end
      if (exp_clr) begin
        chk(clear_done == 1, "R3 R5", "clear_done after finish", 32'(clear_done), 1);
        exp_clr = 0;
      end
      if (abort) begin
        abort_cnt++;
        cur_abt = 1;
        if (!hang)
          chk(0, "R4", "abort on a job that finishes in time", 1, 0);
        else if (abort_cnt == 1)
          chk(cyc - start_cyc == TO, "R4", "first abort delay", 32'(cyc - start_cyc), TO);
        else
          chk(cyc - last_abort == TO, "R4", "repeat abort spacing", 32'(cyc - last_abort), TO);
        last_abort = cyc;
        if (hang && abort_cnt == 2) en_cnt = 2;
      end
      if (clear_done) begin ret_q.push_back(cur_abt); cur_abt = 0; end
      if (ret_valid) begin
        chk(32'(ret_slot) == 32'(exp_slot), "R6", "retire slot order", 32'(ret_slot), 32'(exp_slot));
        if (ret_q.size() == 0) chk(0, "R6", "retire without finish", 1, 0);
        else begin
          bit e;
          e = ret_q.pop_front();
          chk(ret_aborted == e, "R6 R5", "retire aborted flag", 32'(ret_aborted), 32'(e));
        end
        exp_slot = (exp_slot + 1) % SLOTS;
      end
      if (start) begin
        if (addr_q.size() == 0) chk(0, "R2", "start with no job waiting", 1, 0);
        else begin
          logic [AW-1:0] a;
          a = addr_q.pop_front();
          chk(start_addr == a, "R2", "start address order", start_addr, a);
        end
        busy = 1;
        start_cyc = cyc;
        abort_cnt = 0;
        left = $urandom_range(0, max_dly);
      end
      if (busy && !hang) begin
        if (left == 0) begin chan_done = 1; exp_clr = 1; busy = 0; end
        else left--;
      end
      if (busy && hang && en_cnt >= 0) begin
        if (en_cnt == 0) begin
          chan_en = 0; en_low = 1; exp_clr = 1; busy = 0; hang = 0; en_cnt = -1;
        end else en_cnt--;
      end
    end
  end

  task automatic submit(input logic [AW-1:0] a);
    while (!sub_ready) @(negedge clk);
    sub_valid = 1; sub_addr = a; #1;
    chk(sub_handle == exp_h + 1, "R1", "handle", sub_handle, exp_h + 1);
    exp_h++;
    addr_q.push_back(a);
    @(negedge clk);
    sub_valid = 0;
    q_handle = exp_h; #1;
    chk(q_pending == 1, "R7", "new handle pending", 32'(q_pending), 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (chan_off && !busy && addr_q.size() == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    q_handle = 32'd1; #1;
    chk(sub_ready == 1, "R9", "ready after reset", 32'(sub_ready), 1);
    chk(chan_off == 1, "R8", "off after reset", 32'(chan_off), 1);
    chk(start == 0 && abort == 0 && ret_valid == 0, "R2", "quiet after reset", 32'(start), 0);
    chk(q_pending == 0, "R7", "unissued handle", 32'(q_pending), 0);

    submit(32'h1000_0000);
    drain();
    q_handle = 32'd1; #1;
    chk(q_pending == 0, "R7", "finished handle", 32'(q_pending), 0);

    max_dly = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i == 0) max_dly = 30;
      submit(32'h2000_0000 + 32'(i * 16));
    end
    #1;
    chk(sub_ready == 0, "R9", "ring full", 32'(sub_ready), 0);
    sub_valid = 1; sub_addr = 32'hDEAD_BEE0;
    @(negedge clk);
    sub_valid = 0;
    drain();
    max_dly = 6;
    chk(exp_h == 32'd5, "R9", "handles before refusal", exp_h, 5);
    submit(32'h3000_0000);
    drain();

    hang = 1;
    submit(32'h4000_0000);
    drain();
    chk(abort_cnt == 2, "R5", "aborts before enable drop", 32'(abort_cnt), 2);
    chk(hang == 0, "R5", "aborted job finished", 32'(hang), 0);

    for (int j = 0; j < 60; j++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      submit(32'h5000_0000 + 32'($urandom_range(0, 4095)) * 16);
    end
    drain();
    #1;
    chk(chan_off == 1, "R8", "off after drain", 32'(chan_off), 1);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] h;
      h = exp_h - 32'($urandom_range(0, 10)) + 32'd2;
      q_handle = h; #1;
      chk(q_pending == pend_model(exp_h, exp_h, h), "R7", "query after drain",
          32'(q_pending), 32'(pend_model(exp_h, exp_h, h)));
    end
    q_handle = exp_h + 32'h0100_0000; #1;
    chk(q_pending == 0, "R7", "far future handle", 32'(q_pending), 0);
    q_handle = exp_h - 32'h0100_0000; #1;
    chk(q_pending == 0, "R7", "far past handle", 32'(q_pending), 0);
    chk(ret_q.size() == 0, "R6", "unretired finishes", 32'(ret_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule